// File: doc/BRIEF.md
# Transmit/Receive FIFO Pair with Fill-Level Triggers

This block holds the two data queues of a serial communication peripheral. On the bus side, software (or a DMA engine) writes outgoing bytes into a transmit queue through one data port and reads incoming bytes from a receive queue through another. On the line side, the serializer takes transmit bytes and hands over received bytes through valid/ready handshakes.

Each queue has a programmable fill-level threshold. When the threshold is met, the block raises an interrupt request and a DMA trigger for that direction. Each threshold guarantees a known number of entries:

- For receive, the guaranteed number is the count of bytes waiting, so a service routine can read exactly that many without running dry.
- For transmit, the guaranteed number is the count of free slots, so a routine can write exactly that many without losing data.

A debug qualifier on bus accesses lets a debugger look at the receive head without consuming it. Debug writes to the transmit queue behave like ordinary writes. A module-enable input freezes the serializer side without discarding queued data.

Top module: `lvl_fifo_pair`

## Requirements
- R1: After reset both queues are empty, both threshold selects hold code 2 (half, 4 entries), and both sticky error flags are low.
- R2: A bus write to a non-full transmit queue stores the byte at the tail. `tx_valid`/`tx_data` present the oldest byte, and a cycle with `tx_valid && tx_ready` removes it, so bytes leave in write order.
- R3: A transmit write with `bus_dbg` high is stored exactly as a normal write.
- R4: A transmit write that finds the queue holding 8 entries is discarded and sets `tx_ovf`. `tx_ovf` stays high until reset.
- R5: A received byte is stored when `rx_valid && rx_ready`. `bus_rdata` shows the oldest stored byte, and a non-debug `bus_rd` removes it, so bytes are read in arrival order.
- R6: A `bus_rd` with `bus_dbg` high returns the oldest byte and leaves the receive queue unchanged.
- R7: While the receive queue is empty, `bus_rdata` is zero. A non-debug `bus_rd` on an empty queue sets `rx_unf`, which stays high until reset.
- R8: `rx_irq` and `rx_dma` are high exactly while the receive occupancy is at least T. Select codes 0,1,2,3,4 give T = 1,2,4,6,8, and codes 5 to 7 give T = 4.
- R9: `tx_irq` and `tx_dma` are high exactly while the free transmit slots (8 minus occupancy) number at least T, with the same code table as R8.
- R10: The trigger outputs follow occupancy in the same cycle it changes, and drop as soon as their condition fails.
- R11: A store and a removal on the same queue in one cycle leave its occupancy unchanged and keep byte order.
- R12: While `en` is low, `tx_valid` and `rx_ready` are low, and queued bytes are kept for when `en` returns high.
- R13: A cycle with `cfg_wr` high loads both threshold selects from `rx_lvl_sel`/`tx_lvl_sel`. The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Module enable; gates the serializer handshakes |
| cfg_wr | input | 1 | Load strobe for the threshold selects |
| rx_lvl_sel | input | 3 | Receive threshold select code |
| tx_lvl_sel | input | 3 | Transmit threshold select code |
| bus_wr | input | 1 | Bus write to the transmit data port |
| bus_rd | input | 1 | Bus read of the receive data port |
| bus_dbg | input | 1 | Marks the bus access as a debugger access |
| bus_wdata | input | 8 | Transmit write data |
| bus_rdata | output | 8 | Receive head byte, zero when empty |
| tx_valid | output | 1 | Transmit byte available to the serializer |
| tx_ready | input | 1 | Serializer takes the transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Serializer offers a received byte |
| rx_ready | output | 1 | Receive queue can accept a byte |
| rx_data | input | 8 | Received byte |
| rx_irq | output | 1 | Receive threshold interrupt request |
| rx_dma | output | 1 | Receive DMA trigger |
| tx_irq | output | 1 | Transmit threshold interrupt request |
| tx_dma | output | 1 | Transmit DMA trigger |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_unf | output | 1 | Sticky receive underflow flag |

## Verification
A wrong occupancy count appears at the trigger outputs in the same cycle, because they are decoded combinationally from the count. It also appears at `rx_ready`/`tx_valid` once the queue reaches a boundary. A corrupted pointer shows up on `bus_rdata` or `tx_data` as an out-of-order byte at the next access. The bench therefore compares every output against a queue-based model on every cycle, so any divergence is reported in the cycle it first becomes visible. The threshold sweeps walk every select code through every occupancy, so a misdecoded code is exposed at the exact level where it differs.

// File: rtl/lvl_fifo_pair.sv
module lvl_fifo_pair #(
  parameter int DEPTH = 8,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cfg_wr,
  input  logic [2:0]   rx_lvl_sel,
  input  logic [2:0]   tx_lvl_sel,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic         bus_dbg,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         tx_valid,
  input  logic         tx_ready,
  output logic [W-1:0] tx_data,
  input  logic         rx_valid,
  output logic         rx_ready,
  input  logic [W-1:0] rx_data,
  output logic         rx_irq,
  output logic         rx_dma,
  output logic         tx_irq,
  output logic         tx_dma,
  output logic         tx_ovf,
  output logic         rx_unf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [2:0] HALF = 3'd2;

  function automatic int thr(input logic [2:0] s);
    case (s)
      3'd0: thr = DEPTH / 8;
      3'd1: thr = DEPTH / 4;
      3'd3: thr = (3 * DEPTH) / 4;
      3'd4: thr = DEPTH;
      default: thr = DEPTH / 2;
    endcase
  endfunction

  logic [W-1:0]  tx_mem [DEPTH];
  logic [W-1:0]  rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [2:0]    rx_sel, tx_sel;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;
  wire tx_push  = bus_wr && !tx_full;
  wire tx_pop   = tx_valid && tx_ready;
  wire rx_push  = rx_valid && rx_ready;
  wire rx_pop   = bus_rd && !bus_dbg && !rx_empty;

  assign tx_valid  = en && tx_cnt != '0;
  assign tx_data   = tx_mem[tx_rp];
  assign rx_ready  = en && !rx_full;
  assign bus_rdata = rx_empty ? '0 : rx_mem[rx_rp];
  assign rx_irq    = int'(rx_cnt) >= thr(rx_sel);
  assign rx_dma    = rx_irq;
  assign tx_irq    = DEPTH - int'(tx_cnt) >= thr(tx_sel);
  assign tx_dma    = tx_irq;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      rx_sel <= HALF; tx_sel <= HALF;
      tx_ovf <= 1'b0; rx_unf <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(1);
      if (tx_pop)  tx_rp <= tx_rp + AW'(1);
      if (rx_push) rx_wp <= rx_wp + AW'(1);
      if (rx_pop)  rx_rp <= rx_rp + AW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      if (bus_wr && tx_full) tx_ovf <= 1'b1;
      if (bus_rd && !bus_dbg && rx_empty) rx_unf <= 1'b1;
      if (cfg_wr) begin
        rx_sel <= rx_lvl_sel;
        tx_sel <= tx_lvl_sel;
      end
    end
  end

  assert_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tx_valid && !rx_ready);
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf);
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && !tx_pop |=> tx_full);
  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unf |=> rx_unf);
  assert_dbg_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_dbg && !rx_push |=> $stable(rx_cnt) && $stable(bus_rdata));
  assert_same_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_pop |=> $stable(rx_cnt));
  assert_rx_full_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_irq && rx_dma);
  assert_tx_empty_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt == '0 |-> tx_irq && tx_dma);
endmodule

// File: tb/lvl_fifo_pair_tb.sv
module lvl_fifo_pair_tb;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cfg_wr = 1'b0;
  logic [2:0] rx_lvl_sel = 3'd0, tx_lvl_sel = 3'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_dbg = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] bus_wdata = 8'h0, rx_data = 8'h0;
  logic [7:0] bus_rdata, tx_data;
  logic tx_valid, rx_ready, rx_irq, rx_dma, tx_irq, tx_dma, tx_ovf, rx_unf;

  always #2 clk = ~clk;

  lvl_fifo_pair u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr),
    .rx_lvl_sel(rx_lvl_sel), .tx_lvl_sel(tx_lvl_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_dbg(bus_dbg),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_irq(rx_irq), .rx_dma(rx_dma), .tx_irq(tx_irq), .tx_dma(tx_dma),
    .tx_ovf(tx_ovf), .rx_unf(rx_unf));

  int checks = 0, failures = 0;
  logic [7:0] txq[$], rxq[$];
  int rsel = 2, tsel = 2;
  bit m_ovf = 0, m_unf = 0;

  function automatic int level(input int s);
    case (s)
      0: return 1;
      1: return 2;
      3: return 6;
      4: return 8;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    cfg_wr = 0; bus_wr = 0; bus_rd = 0; bus_dbg = 0; tx_ready = 0; rx_valid = 0;
  endtask

  // compare all outputs before the edge, then advance the model across it
  task automatic step(input string tag);
    bit ev_tx, ev_rx, tpop, rpop, tpush, rpush;
    @(negedge clk);
    ev_tx = en && txq.size() > 0;
    ev_rx = en && rxq.size() < 8;
    chk(tag, "tx_valid", tx_valid, ev_tx);
    chk(tag, "rx_ready", rx_ready, ev_rx);
    if (ev_tx) chk(tag, "tx_data", tx_data, txq[0]);
    chk(tag, "bus_rdata", bus_rdata, rxq.size() > 0 ? rxq[0] : 0);
    chk(tag, "rx_irq", rx_irq, rxq.size() >= level(rsel));
    chk(tag, "rx_dma", rx_dma, rxq.size() >= level(rsel));
    chk(tag, "tx_irq", tx_irq, 8 - txq.size() >= level(tsel));
    chk(tag, "tx_dma", tx_dma, 8 - txq.size() >= level(tsel));
    chk(tag, "tx_ovf", tx_ovf, m_ovf);
    chk(tag, "rx_unf", rx_unf, m_unf);
    tpop = ev_tx && tx_ready;
    rpush = ev_rx && rx_valid;
    tpush = bus_wr && txq.size() < 8;
    rpop = bus_rd && !bus_dbg && rxq.size() > 0;
    if (bus_wr && txq.size() == 8) m_ovf = 1;
    if (bus_rd && !bus_dbg && rxq.size() == 0) m_unf = 1;
    if (tpop) void'(txq.pop_front());
    if (tpush) txq.push_back(bus_wdata);
    if (rpop) void'(rxq.pop_front());
    if (rpush) rxq.push_back(rx_data);
    if (cfg_wr) begin rsel = rx_lvl_sel; tsel = tx_lvl_sel; end
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int r, input int t);
    cfg_wr = 1; rx_lvl_sel = 3'(r); tx_lvl_sel = 3'(t); step("R13"); idle();
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    step("R1");
    en = 1;
    // R2: fill then drain in order
    for (int i = 0; i < 5; i++) begin bus_wr = 1; bus_wdata = 8'h10 + 8'(i); step("R2"); end
    idle();
    tx_ready = 1;
    for (int i = 0; i < 6; i++) step("R2");
    idle();
    // R3: debug writes store like normal ones
    bus_dbg = 1;
    for (int i = 0; i < 3; i++) begin bus_wr = 1; bus_wdata = 8'hA0 + 8'(i); step("R3"); end
    idle(); tx_ready = 1;
    for (int i = 0; i < 3; i++) step("R3");
    idle();
    // R4 with R12: disabled, fill past full
    en = 0;
    for (int i = 0; i < 10; i++) begin bus_wr = 1; bus_wdata = 8'h30 + 8'(i); step("R4"); end
    idle(); tx_ready = 1;
    step("R12");
    en = 1;
    for (int i = 0; i < 9; i++) step("R4");
    idle();
    // R5: receive in order
    for (int i = 0; i < 6; i++) begin rx_valid = 1; rx_data = 8'h50 + 8'(i); step("R5"); end
    idle();
    // R6: debug reads do not consume
    bus_rd = 1; bus_dbg = 1;
    for (int i = 0; i < 3; i++) step("R6");
    idle(); bus_rd = 1;
    for (int i = 0; i < 6; i++) step("R5");
    // R7: reading empty
    step("R7");
    idle();
    step("R7");
    // R8/R9/R10: every code against every level
    for (int c = 0; c < 8; c++) begin
      cfg(c, c);
      for (int i = 0; i < 9; i++) begin
        rx_valid = 1; rx_data = 8'(c * 16 + i); bus_wr = 1; bus_wdata = 8'(i + 7 * c);
        step("R8");
      end
      idle(); bus_rd = 1; tx_ready = 1;
      for (int i = 0; i < 9; i++) step("R9");
      idle();
    end
    // R11: simultaneous push and pop on both queues
    cfg(2, 2);
    for (int i = 0; i < 3; i++) begin rx_valid = 1; rx_data = 8'hC0 + 8'(i); bus_wr = 1; bus_wdata = 8'hD0 + 8'(i); step("R11"); end
    for (int i = 0; i < 6; i++) begin
      rx_valid = 1; rx_data = 8'hE0 + 8'(i); bus_rd = 1;
      bus_wr = 1; bus_wdata = 8'hF0 + 8'(i); tx_ready = 1;
      step("R11");
    end
    idle(); bus_rd = 1; tx_ready = 1;
    for (int i = 0; i < 4; i++) step("R11");
    idle();
    // R12: disabled serializer side keeps contents
    for (int i = 0; i < 2; i++) begin rx_valid = 1; rx_data = 8'h70 + 8'(i); bus_wr = 1; bus_wdata = 8'h80 + 8'(i); step("R12"); end
    idle(); en = 0; rx_valid = 1; rx_data = 8'hEE; tx_ready = 1;
    for (int i = 0; i < 4; i++) step("R12");
    en = 1; idle(); bus_rd = 1; tx_ready = 1;
    for (int i = 0; i < 3; i++) step("R12");
    idle();
    step("R12");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule